// File: doc/BRIEF.md
# Conditional Shadow Stack-Pointer Capture

This block holds a microsequencer's small stack-pointer register together with a shadow copy of it. The stack pointer changes only through explicit writes. The shadow changes only as a side effect of a microcode call. The call's 16-bit control-store target address is decoded on every call strobe. If the target lies in the new-instruction region, the shadow takes the value the stack pointer holds in that cycle.

A target qualifies when two conditions hold. The page field, bits 11..10 of the address, must equal binary 01; with 256-word pages this covers pages 4 to 7. The two least significant address bits must also equal binary 01. All other address bits take no part in the decision. A one-cycle pulse marks each capture so that other logic can watch it. When a write to the stack pointer lands in the same cycle as a qualifying call, the shadow keeps the value from before the write.

Top module: `sstk_capture`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `sp_q`, `shadow_q` and `capture_pulse` all at 0.
- R2: A call (`call_valid`=1) whose target has bits 11..10 = 01 and bits 1..0 = 01 loads `shadow_q` with the `sp_q` value of that cycle. The new value is visible after the same rising edge.
- R3: A call whose target has bits 11..10 other than 01 leaves `shadow_q` unchanged, whatever the low bits are. Targets in pages 0, 8 and 12 are examples.
- R4: A call into pages 4..7 whose bits 1..0 are 00, 10 or 11 leaves `shadow_q` unchanged. Offsets 14, 16 and 17 octal are examples.
- R5: With `call_valid`=0, `shadow_q` holds its value. This is true even when the address bus carries a qualifying target or the stack pointer is written.
- R6: When a qualifying call and a stack-pointer write share a cycle, `shadow_q` takes the value from before the write, and `sp_q` takes the written value.
- R7: `capture_pulse` is 1 for exactly the one cycle after each qualifying call, and 0 after any other cycle.
- R8: `sp_wr_en`=1 loads `sp_q` with `sp_wr_data` at the rising edge. With `sp_wr_en`=0, `sp_q` holds its value.
- R9: Address bits 15..12 and 7..2 do not affect whether a call qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| call_valid | input | 1 | Microcode call strobe |
| call_addr | input | 16 | Control-store target address of the call |
| sp_wr_en | input | 1 | Explicit stack-pointer write enable |
| sp_wr_data | input | 8 | Value written to the stack pointer |
| sp_q | output | 8 | Live stack pointer |
| shadow_q | output | 8 | Shadow stack pointer |
| capture_pulse | output | 1 | High for one cycle after each capture |

## Verification
Calls go to offset 15 octal in every page of the region and in pages 0, 8 and 12. This separates a decoder that tests the page field correctly from one that tests the wrong bits. Calls to offsets 14, 16 and 17 octal inside the region check that the low-bit test rejects each of its three wrong patterns. Targets with ones in the upper nibble and in bits 7..2 confirm that those bits are ignored. A write that coincides with a capture shows whether the shadow takes the old or the new stack-pointer value.

// File: rtl/sstk_pkg.sv
// Package: shared constants and types for the shadow stack-pointer capture.
// Assumes a 16-bit control-store address and a stack pointer of at most 16 bits.
package sstk_pkg;

    // Width of the control-store address bus.
    localparam int unsigned ADDR_W = 16;

    // Width of the stack pointer.
    localparam int unsigned SP_W   = 8;

    // Outcome of decoding one call target, kept apart so that
    // observers can see which half of the test failed.
    typedef struct packed {
        logic page_hit;   // page field matches the region
        logic low_hit;    // low address bits match the entry offset
    } tgt_decode_t;

endpackage

// File: rtl/sstk_addr_decode.sv
// Module: sstk_addr_decode
// Purely combinational check of whether a call target lies in the
// new-instruction region. Two fields of the address are compared with
// constants. Every other bit is a don't-care.
// Assumes PAGE_MSB >= PAGE_LSB and that both fields fit within ADDR_W.
module sstk_addr_decode
    import sstk_pkg::*;
#(
    parameter int unsigned            AW         = ADDR_W,
    parameter int unsigned            PAGE_MSB   = 11,
    parameter int unsigned            PAGE_LSB   = 10,
    parameter logic [PAGE_MSB-PAGE_LSB:0] PAGE_MATCH = 2'b01,
    parameter int unsigned            LOW_W      = 2,
    parameter logic [LOW_W-1:0]       LOW_MATCH  = 2'b01
) (
    input  logic [AW-1:0] addr,
    output tgt_decode_t   dec,
    output logic          hit
);

    localparam int unsigned PAGE_W = PAGE_MSB - PAGE_LSB + 1;

    logic [PAGE_W-1:0] page_field;
    logic [LOW_W-1:0]  low_field;

    // Slice out the two fields that take part in the decision.
    always_comb begin
        page_field = addr[PAGE_MSB:PAGE_LSB];
        low_field  = addr[LOW_W-1:0];
    end

    // Compare each field with its pattern and combine the results.
    always_comb begin
        dec.page_hit = (page_field == PAGE_MATCH);
        dec.low_hit  = (low_field  == LOW_MATCH);
        hit          = dec.page_hit & dec.low_hit;
    end

endmodule

// File: rtl/sstk_sp_reg.sv
// Module: sstk_sp_reg
// The live stack-pointer register. It changes only on an explicit write.
// Assumes a synchronous active-low reset that clears it to zero.
module sstk_sp_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);

    // Load the written value, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_data;
    end

endmodule

// File: rtl/sstk_shadow_reg.sv
// Module: sstk_shadow_reg
// The shadow copy of the stack pointer and the capture pulse. It loads
// only when the load strobe is high, sampling src as it stands before the
// edge, so a write to src in the same cycle is not seen.
// Assumes the caller has already qualified the strobe.
module sstk_shadow_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] src,
    output logic [W-1:0] q,
    output logic         pulse
);

    // Capture the source value on a qualified load, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= src;
    end

    // Mark each load with one cycle of pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= load;
    end

endmodule

// File: rtl/sstk_capture.sv
// Module: sstk_capture (top)
// Wires the stack pointer, the call-target decoder and the shadow register.
// A call whose target decodes into the new-instruction region copies the
// current stack pointer into the shadow. Nothing else touches the shadow.
// Assumes call_valid is high for one cycle per call.
module sstk_capture
    import sstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_valid,
    input  logic [ADDR_W-1:0] call_addr,
    input  logic              sp_wr_en,
    input  logic [SP_W-1:0]   sp_wr_data,
    output logic [SP_W-1:0]   sp_q,
    output logic [SP_W-1:0]   shadow_q,
    output logic              capture_pulse
);

    tgt_decode_t tgt_dec;
    logic        tgt_hit;
    logic        cap_load;

    sstk_sp_reg #(.W(SP_W)) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sp_wr_en),
        .wr_data (sp_wr_data),
        .q       (sp_q)
    );

    sstk_addr_decode #(.AW(ADDR_W)) u_dec (
        .addr (call_addr),
        .dec  (tgt_dec),
        .hit  (tgt_hit)
    );

    // A capture needs both a call strobe and a region hit.
    always_comb cap_load = call_valid & tgt_hit;

    sstk_shadow_reg #(.W(SP_W)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap_load),
        .src   (sp_q),
        .q     (shadow_q),
        .pulse (capture_pulse)
    );

endmodule

// File: rtl/sstk_capture_chk.sv
// Module: sstk_capture_chk
// Checker bound to sstk_capture. It watches only the top-level ports and
// decodes the region itself from the address bits.
module sstk_capture_chk
    import sstk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              call_valid,
    input logic [ADDR_W-1:0] call_addr,
    input logic              sp_wr_en,
    input logic [SP_W-1:0]   sp_wr_data,
    input logic [SP_W-1:0]   sp_q,
    input logic [SP_W-1:0]   shadow_q,
    input logic              capture_pulse
);

    logic qual;

    // Independent view of a qualifying call.
    always_comb qual = call_valid && (call_addr[11:10] == 2'b01) && (call_addr[1:0] == 2'b01);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (sp_q == '0 && shadow_q == '0 && !capture_pulse));

    a_r2_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> shadow_q == $past(sp_q));

    a_r3_r4_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && !qual) |=> $stable(shadow_q));

    a_r5_no_call_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !call_valid |=> $stable(shadow_q));

    a_r6_prewrite_value: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && sp_wr_en) |=> (shadow_q == $past(sp_q) && sp_q == $past(sp_wr_data)));

    a_r7_pulse_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> capture_pulse);

    a_r7_pulse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> !capture_pulse);

    a_r8_sp_write: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr_en |=> sp_q == $past(sp_wr_data));

    a_r8_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_wr_en |=> $stable(sp_q));

endmodule

bind sstk_capture sstk_capture_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .call_valid    (call_valid),
    .call_addr     (call_addr),
    .sp_wr_en      (sp_wr_en),
    .sp_wr_data    (sp_wr_data),
    .sp_q          (sp_q),
    .shadow_q      (shadow_q),
    .capture_pulse (capture_pulse)
);

// File: tb/test_sstk_capture.sv
module test_sstk_capture;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_valid = 1'b0;
    logic [15:0] call_addr = '0;
    logic        sp_wr_en = 1'b0;
    logic [7:0]  sp_wr_data = '0;
    logic [7:0]  sp_q;
    logic [7:0]  shadow_q;
    logic        capture_pulse;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    sstk_capture i_sstk_capture (
        .clk           (clk),
        .rst_n         (rst_n),
        .call_valid    (call_valid),
        .call_addr     (call_addr),
        .sp_wr_en      (sp_wr_en),
        .sp_wr_data    (sp_wr_data),
        .sp_q          (sp_q),
        .shadow_q      (shadow_q),
        .capture_pulse (capture_pulse)
    );

    // Vector fields: req, call, addr, wr, wdata, exp_sp, exp_shadow, exp_pulse.
    typedef struct packed {
        logic [3:0]  req;
        logic        call;
        logic [15:0] addr;
        logic        wr;
        logic [7:0]  wdata;
        logic [7:0]  e_sp;
        logic [7:0]  e_sh;
        logic        e_pl;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{4'd8, 1'b0, 16'h0000, 1'b1, 8'h3C, 8'h3C, 8'h00, 1'b0}, // R8 write sp
        '{4'd2, 1'b1, 16'h040D, 1'b0, 8'h00, 8'h3C, 8'h3C, 1'b1}, // R2 octal 2015
        '{4'd5, 1'b0, 16'h040D, 1'b1, 8'h55, 8'h55, 8'h3C, 1'b0}, // R5 no strobe
        '{4'd4, 1'b1, 16'h040C, 1'b0, 8'h00, 8'h55, 8'h3C, 1'b0}, // R4 offset 14
        '{4'd4, 1'b1, 16'h040E, 1'b0, 8'h00, 8'h55, 8'h3C, 1'b0}, // R4 offset 16
        '{4'd4, 1'b1, 16'h040F, 1'b0, 8'h00, 8'h55, 8'h3C, 1'b0}, // R4 offset 17
        '{4'd3, 1'b1, 16'h000D, 1'b0, 8'h00, 8'h55, 8'h3C, 1'b0}, // R3 page 0
        '{4'd3, 1'b1, 16'h0C0D, 1'b0, 8'h00, 8'h55, 8'h3C, 1'b0}, // R3 page 12
        '{4'd3, 1'b1, 16'h080D, 1'b0, 8'h00, 8'h55, 8'h3C, 1'b0}, // R3 page 8
        '{4'd2, 1'b1, 16'h070D, 1'b0, 8'h00, 8'h55, 8'h55, 1'b1}, // R2 page 7
        '{4'd6, 1'b1, 16'h050D, 1'b1, 8'h81, 8'h81, 8'h55, 1'b1}, // R6 same-cycle write
        '{4'd7, 1'b0, 16'h0000, 1'b0, 8'h00, 8'h81, 8'h55, 1'b0}, // R7 pulse drops
        '{4'd9, 1'b1, 16'hF6F1, 1'b0, 8'h00, 8'h81, 8'h81, 1'b1}, // R9 high bits set
        '{4'd9, 1'b1, 16'h06FD, 1'b1, 8'h00, 8'h00, 8'h81, 1'b1}, // R9 middle bits set
        '{4'd2, 1'b1, 16'h0401, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1}, // R2 offset 1
        '{4'd3, 1'b1, 16'hFB05, 1'b1, 8'hA7, 8'hA7, 8'h00, 1'b0}, // R3 page 11
        '{4'd7, 1'b0, 16'h0000, 1'b0, 8'h00, 8'hA7, 8'h00, 1'b0}  // R7 stays low
    };

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic [15:0] a, input logic w, input logic [7:0] d);
        call_valid = c; call_addr = a; sp_wr_en = w; sp_wr_data = d;
        @(negedge clk);
        call_valid = 1'b0; sp_wr_en = 1'b0;
    endtask

    initial begin : watchdog
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check8("R1 sp", sp_q, 8'h00);
        check8("R1 shadow", shadow_q, 8'h00);
        check8("R1 pulse", {7'd0, capture_pulse}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].call, VECS[i].addr, VECS[i].wr, VECS[i].wdata);
            check8($sformatf("R%0d row %0d sp", VECS[i].req, i), sp_q, VECS[i].e_sp);
            check8($sformatf("R%0d row %0d shadow", VECS[i].req, i), shadow_q, VECS[i].e_sh);
            check8($sformatf("R%0d row %0d pulse", VECS[i].req, i), {7'd0, capture_pulse}, {7'd0, VECS[i].e_pl});
        end

        // R7: back-to-back qualifying calls give one pulse each
        step(1'b1, 16'h060D, 1'b0, 8'h00);
        check8("R7 first pulse", {7'd0, capture_pulse}, 8'h01);
        check8("R2 back-to-back shadow", shadow_q, 8'hA7);
        step(1'b1, 16'h050D, 1'b1, 8'h12);
        check8("R7 second pulse", {7'd0, capture_pulse}, 8'h01);
        check8("R6 second capture pre-write", shadow_q, 8'hA7);
        step(1'b0, 16'h050D, 1'b0, 8'h00);
        check8("R7 after pair", {7'd0, capture_pulse}, 8'h00);
        check8("R5 idle shadow", shadow_q, 8'hA7);

        // R1: reset in mid-run clears everything, even with a qualifying call
        rst_n = 1'b0;
        step(1'b1, 16'h040D, 1'b1, 8'hEE);
        rst_n = 1'b1;
        check8("R1 mid-run sp", sp_q, 8'h00);
        check8("R1 mid-run shadow", shadow_q, 8'h00);
        check8("R1 mid-run pulse", {7'd0, capture_pulse}, 8'h00);

        // R8: hold without write
        step(1'b0, 16'h0000, 1'b0, 8'hFF);
        check8("R8 hold", sp_q, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule